// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a successive-approximation ADC. It owns the register-programmed setup: conversion-clock divide, sample-phase length, result resolution, continuous repeat, trigger mode and overwrite policy. For each conversion it runs a sample phase and then resolves one result bit per conversion-clock tick, MSB first. On every tick it drives a trial code to an external DAC and samples the comparator's verdict. The finished code goes into a result register, and a one-cycle done strobe marks the end of the conversion.

Each channel group has its own channel-select register. In software-trigger mode, a write to group 0's register starts a conversion on that channel. In hardware-trigger mode, each rising edge of the trigger input starts the next group in round-robin order. Only one group converts at a time. A write to the channel register of the group now converting abandons that conversion.

Top module: `sar_sequencer`

## Requirements
- R1: After reset, the control register (address 0) reads 0x040. Its fields are: [1:0] divider code, [3:2] sample code, [4] long-sample flag, [6:5] resolution code, [7] continuous, [8] overwrite enable, [9] hardware-trigger mode. The defaults are 12-bit, divide-by-1, short sample of 2 cycles, software trigger. The status register (address 1), the result register (address 2) and done all read 0.
- R2: In software mode, a write to the group 0 channel register (address 4, bits [4:0]) starts a conversion of that channel. The done strobe is high for exactly one cycle. It appears (S+B)·D clock edges after the write edge, where S is the sample length in ticks, B the resolution in bits and D the divide ratio.
- R3: Sample code c gives a sample phase of 2+2c conversion-clock ticks when the long-sample flag is 0, and 12+4c ticks when it is 1.
- R4: Divider code d makes one conversion-clock tick every 2^d input clocks.
- R5: Resolution code 0 gives 8 bits, code 1 gives 10 bits, and codes 2 and 3 give 12 bits. dac_code is MSB-aligned on 12 bits and is 0x800 during the first approximation tick. The result is right-justified: it is the input value shifted right by 12−B.
- R6: In software mode, a write to a channel register of group 1 or higher (address 4+g) starts nothing.
- R7: In hardware mode, a rising edge of hw_trig while idle starts groups 0, 1, … in turn. A trigger while busy is ignored. A channel-register write starts nothing.
- R8: A write to the channel register of the group now converting aborts the conversion: there is no done strobe and the result is unchanged. A write to another group's register does not disturb the conversion.
- R9: With the continuous bit set, a new conversion of the same group begins at each completion, so done strobes repeat every (S+B)·D clocks.
- R10: A result that has not been read is kept when the overwrite bit is 0, although done still pulses. It is replaced when the bit is 1. A read strobe at address 2 marks the result as read.
- R11: Status bit 0 shows a conversion in progress and bit 1 shows an unread result. Writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (marks the result as read at address 2) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| hw_trig | input | 1 | Hardware trigger, acts on its rising edge |
| cmp_in | input | 1 | Comparator verdict: input ≥ dac_code |
| dac_code | output | 12 | MSB-aligned trial code, zero when not approximating |
| chan_sel | output | 5 | Channel of the active group |
| smp_on | output | 1 | High during the sample phase |
| result | output | 12 | Right-justified conversion result |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bench builds the block with its defaults: two channel groups, 5-bit channels, 12-bit results and a 4-bit address space. With two groups, the round-robin hand-off, abort of the active group and an undisturbed conversion while the other group is written can all be reached. The vector walk covers every divider code, the short and long sample meanings and all resolution codes, including the reserved one. Latencies range from 14 to 144 clocks, so each timing is checked to the exact edge.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int CTRL_W     = 10;
  localparam int RES_MAX    = 12;
  localparam int A_CTRL     = 0;
  localparam int A_STAT     = 1;
  localparam int A_RESULT   = 2;
  localparam int A_GRP_BASE = 4;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_CONV   = 2'd2
  } phase_t;

  typedef struct packed {
    logic       hw_mode;
    logic       ovwr;
    logic       cont;
    logic [1:0] res;
    logic       long_smp;
    logic [1:0] smp;
    logic [1:0] div;
  } ctrl_t;

  localparam logic [CTRL_W-1:0] CTRL_RST = 10'h040;

  function automatic logic [4:0] smp_len(input logic [1:0] code, input logic lng);
    logic [4:0] c5;
    c5 = {3'b000, code};
    return lng ? (5'd12 + (c5 << 2)) : (5'd2 + (c5 << 1));
  endfunction

  function automatic logic [3:0] res_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd8;
      2'd1:    return 4'd10;
      default: return 4'd12;
    endcase
  endfunction
endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
  parameter int DIV_CODE_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  clr,
  input  logic [DIV_CODE_W-1:0] div_code,
  output logic                  tick
);
  localparam int CNT_W = (1 << DIV_CODE_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;

  assign lim  = CNT_W'((1 << div_code) - 1);
  assign tick = run && (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (clr || !run || tick) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Divider phase starts fresh with every conversion
  assert_div_fresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt_q == '0));
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int RES_W = 12,
  parameter int NB_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [NB_W-1:0]  nbits,
  input  logic             cmp_in,
  output logic [RES_W-1:0] trial,
  output logic             last,
  output logic [RES_W-1:0] value
);
  localparam int BP_W = $clog2(RES_W);

  logic [RES_W-1:0] acc_q, acc_d, bitv, keep;
  logic [BP_W-1:0]  bp_q, bp_d, lsb_pos;

  assign lsb_pos = BP_W'(RES_W - int'(nbits));
  assign bitv    = {{(RES_W-1){1'b0}}, 1'b1} << bp_q;
  assign trial   = acc_q | bitv;
  assign keep    = cmp_in ? trial : acc_q;
  assign last    = (bp_q == lsb_pos);
  assign value   = keep >> lsb_pos;

  always_comb begin
    acc_d = acc_q;
    bp_d  = bp_q;
    if (load) begin
      acc_d = '0;
      bp_d  = BP_W'(RES_W - 1);
    end else if (step) begin
      acc_d = keep;
      if (!last) bp_d = bp_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      bp_q  <= '0;
    end else begin
      acc_q <= acc_d;
      bp_q  <= bp_d;
    end
  end

  // First trial after loading is the MSB alone
  assert_msb_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (trial == {1'b1, {(RES_W-1){1'b0}}}));
  // Every non-final decision moves the trial code
  assert_trial_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last && !load) |=> (trial != $past(trial)));
endmodule

// File: rtl/sar_regs.sv
module sar_regs
  import sar_seq_pkg::*;
#(
  parameter int NGROUPS = 2,
  parameter int CH_W    = 5,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int RES_W   = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic                          re,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic                          active,
  input  logic                          unread,
  input  logic [RES_W-1:0]              result,
  output logic [CTRL_W-1:0]             ctrl,
  output logic [NGROUPS-1:0][CH_W-1:0]  chan,
  output logic [NGROUPS-1:0]            grp_wr,
  output logic                          res_rd,
  output logic [DATA_W-1:0]             rdata
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_en;

  assign ctrl_en = we && (addr == ADDR_W'(A_CTRL));
  assign res_rd  = re && (addr == ADDR_W'(A_RESULT));
  assign ctrl    = ctrl_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_en) ctrl_d = wdata[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RST;
    else        ctrl_q <= ctrl_d;
  end

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    logic [CH_W-1:0] ch_q, ch_d;
    assign grp_wr[g] = we && (addr == ADDR_W'(A_GRP_BASE + g));
    always_comb begin
      ch_d = ch_q;
      if (grp_wr[g]) ch_d = wdata[CH_W-1:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ch_q <= '0;
      else        ch_q <= ch_d;
    end
    assign chan[g] = ch_q;
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(A_CTRL))   rdata = DATA_W'(ctrl_q);
    if (addr == ADDR_W'(A_STAT))   rdata = DATA_W'({unread, active});
    if (addr == ADDR_W'(A_RESULT)) rdata = DATA_W'(result);
    for (int g = 0; g < NGROUPS; g++) begin
      if (addr == ADDR_W'(A_GRP_BASE + g)) rdata = DATA_W'(chan[g]);
    end
  end

  // Control write lands whole in the control register
  assert_ctrl_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_en |=> (ctrl_q == $past(wdata[CTRL_W-1:0])));
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_seq_pkg::*;
#(
  parameter int NGROUPS = 2,
  parameter int CH_W    = 5,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              hw_trig,
  input  logic              cmp_in,
  output logic [RES_MAX-1:0] dac_code,
  output logic [CH_W-1:0]   chan_sel,
  output logic              smp_on,
  output logic [RES_MAX-1:0] result,
  output logic              done
);
  localparam int GW = (NGROUPS > 1) ? $clog2(NGROUPS) : 1;

  phase_t                      ph_q, ph_d;
  logic [4:0]                  smp_q, smp_d, slen;
  logic [GW-1:0]               grp_q, grp_d, nxt_q, nxt_d;
  logic [RES_MAX-1:0]          res_q, res_d;
  logic                        unread_q, unread_d, done_q, done_d;
  logic                        trig_q;
  logic [CTRL_W-1:0]           ctrl_raw;
  ctrl_t                       ctrl;
  logic [NGROUPS-1:0][CH_W-1:0] chan;
  logic [NGROUPS-1:0]          grp_wr;
  logic                        res_rd, tick, trig_rise, sw_go, hw_go, abort_hit;
  logic                        ld, cap, last;
  logic [RES_MAX-1:0]          trial, value;

  sar_regs #(
    .NGROUPS(NGROUPS), .CH_W(CH_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RES_W(RES_MAX)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .re(reg_re), .addr(reg_addr),
    .wdata(reg_wdata), .active(ph_q != PH_IDLE), .unread(unread_q), .result(res_q),
    .ctrl(ctrl_raw), .chan(chan), .grp_wr(grp_wr), .res_rd(res_rd), .rdata(reg_rdata)
  );

  assign ctrl      = ctrl_t'(ctrl_raw);
  assign slen      = smp_len(ctrl.smp, ctrl.long_smp);
  assign trig_rise = hw_trig && !trig_q;
  assign sw_go     = !ctrl.hw_mode && grp_wr[0];
  assign hw_go     = ctrl.hw_mode && trig_rise && (ph_q == PH_IDLE);
  assign abort_hit = (ph_q != PH_IDLE) && grp_wr[grp_q];

  sar_clk_div #(.DIV_CODE_W(2)) u_div (
    .clk(clk), .rst_n(rst_n), .run(ph_q != PH_IDLE), .clr(sw_go || hw_go),
    .div_code(ctrl.div), .tick(tick)
  );

  sar_approx #(.RES_W(RES_MAX), .NB_W(4)) u_sar (
    .clk(clk), .rst_n(rst_n), .load(ld), .step(tick && (ph_q == PH_CONV) && !sw_go && !abort_hit),
    .nbits(res_bits(ctrl.res)), .cmp_in(cmp_in), .trial(trial), .last(last), .value(value)
  );

  always_comb begin
    ph_d   = ph_q;
    smp_d  = smp_q;
    grp_d  = grp_q;
    nxt_d  = nxt_q;
    done_d = 1'b0;
    ld     = 1'b0;
    cap    = 1'b0;
    if (sw_go) begin
      ph_d  = PH_SAMPLE;
      smp_d = '0;
      grp_d = '0;
    end else if (hw_go) begin
      ph_d  = PH_SAMPLE;
      smp_d = '0;
      grp_d = nxt_q;
      nxt_d = (nxt_q == GW'(NGROUPS - 1)) ? '0 : nxt_q + 1'b1;
    end else if (abort_hit) begin
      ph_d = PH_IDLE;
    end else if (tick) begin
      case (ph_q)
        PH_SAMPLE: begin
          if (smp_q == slen - 5'd1) begin
            ph_d = PH_CONV;
            ld   = 1'b1;
          end else begin
            smp_d = smp_q + 5'd1;
          end
        end
        PH_CONV: begin
          if (last) begin
            cap    = 1'b1;
            done_d = 1'b1;
            smp_d  = '0;
            ph_d   = ctrl.cont ? PH_SAMPLE : PH_IDLE;
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_comb begin
    res_d = res_q;
    if (cap && (!unread_q || ctrl.ovwr)) res_d = value;
    unread_d = unread_q;
    if (res_rd) unread_d = 1'b0;
    if (cap)    unread_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      smp_q    <= '0;
      grp_q    <= '0;
      nxt_q    <= '0;
      res_q    <= '0;
      unread_q <= 1'b0;
      done_q   <= 1'b0;
      trig_q   <= 1'b0;
    end else begin
      ph_q     <= ph_d;
      smp_q    <= smp_d;
      grp_q    <= grp_d;
      nxt_q    <= nxt_d;
      res_q    <= res_d;
      unread_q <= unread_d;
      done_q   <= done_d;
      trig_q   <= hw_trig;
    end
  end

  assign dac_code = (ph_q == PH_CONV) ? trial : '0;
  assign chan_sel = chan[grp_q];
  assign smp_on   = (ph_q == PH_SAMPLE);
  assign result   = res_q;
  assign done     = done_q;

  // Done is a single-cycle strobe
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // Approximation is only entered from the sample phase
  assert_conv_after_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_CONV && $past(ph_q) != PH_CONV) |-> ($past(ph_q) == PH_SAMPLE));
  // Abort leaves the converter idle with no strobe
  assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_hit && !sw_go) |=> (ph_q == PH_IDLE && !done_q));
  // Unread result is protected without overwrite
  assert_keep_unread_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && unread_q && !ctrl.ovwr) |=> $stable(res_q));
  // Trigger while busy does not move the active group
  assert_busy_trig_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.hw_mode && trig_rise && ph_q != PH_IDLE) |=> (grp_q == $past(grp_q)));
endmodule

// File: tb/tb_sar_sequencer.sv
module tb_sar_sequencer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we, reg_re, hw_trig;
  logic [3:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        cmp_in, smp_on, done;
  logic [11:0] dac_code, result;
  logic [4:0]  chan_sel;
  logic [11:0] vin [32];

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  assign cmp_in = (vin[chan_sel] >= dac_code);

  sar_sequencer dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_trig(hw_trig), .cmp_in(cmp_in),
    .dac_code(dac_code), .chan_sel(chan_sel), .smp_on(smp_on), .result(result), .done(done)
  );

  // {div, smp, long, res, chan, vin, expected result, expected latency}
  localparam logic [43:0] VEC [6] = '{
    {2'd0, 2'd0, 1'b0, 2'd2, 5'd3,  12'hA5C, 12'hA5C, 8'd14},
    {2'd1, 2'd1, 1'b0, 2'd1, 5'd7,  12'h3FF, 12'h0FF, 8'd28},
    {2'd2, 2'd3, 1'b1, 2'd0, 5'd31, 12'hFFF, 12'h0FF, 8'd128},
    {2'd3, 2'd2, 1'b0, 2'd2, 5'd0,  12'h000, 12'h000, 8'd144},
    {2'd0, 2'd2, 1'b1, 2'd3, 5'd12, 12'h800, 12'h800, 8'd32},
    {2'd1, 2'd0, 1'b1, 2'd0, 5'd18, 12'h7F3, 12'h07F, 8'd40}
  };

  function automatic logic [15:0] mkctrl(input logic hw, input logic ov, input logic ct,
      input logic [1:0] rs, input logic lg, input logic [1:0] sm, input logic [1:0] dv);
    return {6'd0, hw, ov, ct, rs, lg, sm, dv};
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ack_result();
    @(negedge clk);
    reg_re = 1'b1; reg_addr = 4'd2;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic trig();
    @(negedge clk);
    hw_trig = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hw_trig = 1'b0;
  endtask

  // Counts edges from the current negedge until done is seen
  task automatic wait_done(output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!done && n < 400);
  endtask

  task automatic count_done(input int cyc, output int cnt);
    cnt = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (done) cnt++;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int n, c;
    for (int i = 0; i < 32; i++) vin[i] = '0;
    reg_we = 0; reg_re = 0; reg_addr = 0; reg_wdata = 0; hw_trig = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 / R11 reset state
    rd(4'd0, d); check(d == 16'h0040, "R1 ctrl reset", d, 16'h0040);
    rd(4'd1, d); check(d == 16'h0000, "R11 status reset", d, 0);
    rd(4'd2, d); check(d == 16'h0000, "R1 result reset", d, 0);
    check(done == 1'b0 && dac_code == 12'h000, "R1 outputs idle", {done, dac_code}, 0);

    // R5 MSB-first trial with defaults (S=2, D=1)
    vin[3] = 12'h5A5;
    @(negedge clk); reg_we = 1'b1; reg_addr = 4'd4; reg_wdata = 16'd3;
    @(posedge clk); @(negedge clk); reg_we = 1'b0;
    check(smp_on == 1'b1, "R3 sample phase begins", smp_on, 1);
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(dac_code == 12'h800, "R5 first trial is MSB", dac_code, 12'h800);
    wait_done(n);
    check(result == 12'h5A5, "R2 default conversion", result, 12'h5A5);

    // Vector walk: R2 R3 R4 R5 timing and value
    foreach (VEC[k]) begin
      logic [43:0] v;
      v = VEC[k];
      vin[v[36:32]] = v[31:20];
      wr(4'd0, mkctrl(1'b0, 1'b1, 1'b0, v[38:37], v[39], v[41:40], v[43:42]));
      wr(4'd4, {11'd0, v[36:32]});
      wait_done(n);
      check(n == int'(v[7:0]), "R2 R3 R4 latency", n, v[7:0]);
      check(result == v[19:8], "R5 resolution result", result, v[19:8]);
      @(negedge clk);
      check(done == 1'b0, "R2 done one cycle", done, 0);
    end

    // R6 group 1 write in software mode starts nothing
    wr(4'd0, mkctrl(0, 1, 0, 2'd2, 0, 2'd0, 2'd0));
    wr(4'd5, 16'd7);
    count_done(40, c);
    rd(4'd1, d);
    check(c == 0 && d[0] == 1'b0, "R6 group1 no start", {c, d[0]}, 0);

    // R11 status register write ignored while busy
    vin[3] = 12'h111;
    wr(4'd4, 16'd3);
    wr(4'd1, 16'h0000);
    rd(4'd1, d);
    check(d[0] == 1'b1, "R11 status write ignored", d[0], 1);
    wait_done(n);
    rd(4'd1, d);
    check(d[0] == 1'b0, "R11 busy clears at done", d[0], 0);

    // R7 hardware mode round robin
    vin[7] = 12'h222;
    wr(4'd0, mkctrl(1, 1, 0, 2'd2, 0, 2'd0, 2'd0));
    wr(4'd4, 16'd3);
    wr(4'd5, 16'd7);
    rd(4'd1, d);
    check(d[0] == 1'b0, "R7 write starts nothing in hw mode", d[0], 0);
    trig(); wait_done(n);
    check(n == 14 && result == 12'h111, "R7 first trigger group0", result, 12'h111);
    trig(); wait_done(n);
    check(result == 12'h222, "R7 second trigger group1", result, 12'h222);
    trig();
    repeat (3) @(negedge clk);
    trig();
    wait_done(n);
    check(result == 12'h111, "R7 third trigger group0", result, 12'h111);
    count_done(30, c);
    check(c == 0, "R7 busy trigger ignored", c, 0);

    // R8 abort active group (group1 next)
    trig();
    repeat (3) @(negedge clk);
    wr(4'd5, 16'd7);
    rd(4'd1, d);
    check(d[0] == 1'b0, "R8 abort clears busy", d[0], 0);
    count_done(30, c);
    check(c == 0 && result == 12'h111, "R8 abort no done, result kept", result, 12'h111);
    vin[3] = 12'h333;
    trig();
    repeat (3) @(negedge clk);
    wr(4'd5, 16'd7);
    wait_done(n);
    check(result == 12'h333, "R8 other group write harmless", result, 12'h333);

    // R9 continuous
    vin[3] = 12'h0C3;
    wr(4'd0, mkctrl(0, 1, 1, 2'd2, 0, 2'd0, 2'd0));
    wr(4'd4, 16'd3);
    wait_done(n);
    wait_done(n);
    check(n == 14, "R9 continuous period", n, 14);
    wait_done(n);
    check(n == 14 && result == 12'h0C3, "R9 continuous repeat", n, 14);
    wr(4'd0, mkctrl(0, 1, 0, 2'd2, 0, 2'd0, 2'd0));
    wait_done(n);
    count_done(40, c);
    check(c == 0, "R9 stops when cleared", c, 0);

    // R10 overwrite policy
    wr(4'd0, mkctrl(0, 0, 0, 2'd2, 0, 2'd0, 2'd0));
    ack_result();
    vin[3] = 12'h111; vin[7] = 12'h222;
    wr(4'd4, 16'd3); wait_done(n);
    rd(4'd1, d);
    check(result == 12'h111 && d[1] == 1'b1, "R10 fresh result unread", result, 12'h111);
    wr(4'd4, 16'd7); wait_done(n);
    check(result == 12'h111, "R10 unread kept", result, 12'h111);
    ack_result();
    rd(4'd1, d);
    check(d[1] == 1'b0, "R10 read clears unread", d[1], 0);
    wr(4'd4, 16'd7); wait_done(n);
    check(result == 12'h222, "R10 update after read", result, 12'h222);
    wr(4'd0, mkctrl(0, 1, 0, 2'd2, 0, 2'd0, 2'd0));
    wr(4'd4, 16'd3); wait_done(n);
    check(result == 12'h111, "R10 overwrite replaces", result, 12'h111);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule